// File: doc/BRIEF.md
# Maskable Dual Time Alarm Unit

This block watches a running BCD time and raises an alarm request when that time matches one of two programmed alarm settings. The first alarm compares seconds, minutes, hours and a day-or-date field. The second alarm compares minutes, hours and a day-or-date field, and it only fires on the zero-second tick. A mask bit in every alarm byte drops that field from the comparison, which gives repeat rates from once a second up to once a month or once a week.

Matches are sampled only when the timekeeper pulses its once-per-second update strobe. A match always sets a sticky flag in the status byte. The control byte chooses whether the output pin carries the alarm interrupt or a square-wave request, and it holds one interrupt enable for each alarm. Software reads and writes all registers through a simple single-cycle register port. Flags are cleared by writing 0 and cannot be set by software.

Top module: `alarm_unit`

## Requirements
- R1: After reset the control byte (address 0) and status byte (address 1) read 0x00, `irq_n` is 1 and `wave_req` is 1.
- R2: Each alarm byte's bit 7 is a mask. A masked field is left out of the match. An unmasked field must equal the current time: seconds, minutes and hours over bits 6..0, and the day/date value over bits 5..0.
- R3: With every mask of alarm 1 set, status bit 0 is set on every update tick, whatever the time.
- R4: In each day/date alarm byte, bit 6 = 0 compares bits 5..0 with `now_date`, and bit 6 = 1 compares them with `now_dow`.
- R5: Alarm 2 has no seconds field. It can only match on a tick where `now_sec` is 0x00, and with all its masks set it fires exactly on those ticks.
- R6: Matches are evaluated only in cycles where `tick` is 1. A matching time without a tick leaves the flags unchanged.
- R7: A match sets status bit 0 (alarm 1) or bit 1 (alarm 2) whatever the values of the enables and the mode bit.
- R8: A status write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Status bits 7..2 always read 0.
- R9: `irq_n` is 0 exactly when control bit 2 (interrupt mode) is 1 and (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1). It stays 0 until the flag is cleared or the enable or mode changes.
- R10: When a tick with a match and a status write that clears the same flag fall in the same cycle, the flag ends set.
- R11: Register map: 0 control, 1 status, 2..5 alarm 1 (seconds, minutes, hours, day/date), 6..8 alarm 2 (minutes, hours, day/date). Registers read back what was written. Writes to addresses 9..15 have no effect, and those addresses read 0x00. `wave_req` equals the inverse of control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking the once-per-second time update |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours byte including the 12/24 and AM/PM bits |
| now_dow | input | 6 | Current day of week |
| now_date | input | 6 | Current date of month, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq_n | output | 1 | Active-low alarm interrupt |
| wave_req | output | 1 | High when the pin should carry the square wave instead of the interrupt |

## Verification
A match on an update tick and a software write that clears the same flag can land in the same clock cycle. The bench drives `tick` with a matching time and a status write of 0x00 on one clock edge, then reads the status back. A dropped alarm (flag 0) counts as a failure. Mask and field coverage uses full sweeps: every mask combination crossed with every choice of which fields disagree, checked against a match result the bench works out from the requirements.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int ALM_N   = 2;   // number of alarms
    localparam int FLD_N   = 4;   // field slots per alarm (sec, min, hour, day/date)
    localparam int DW      = 8;
    localparam int AW      = 4;

    localparam logic [AW-1:0] ADDR_CTRL = 4'd0;
    localparam logic [AW-1:0] ADDR_STAT = 4'd1;

    // control bit positions
    localparam int CTL_EN0  = 0;
    localparam int CTL_EN1  = 1;
    localparam int CTL_MODE = 2;

    typedef logic [FLD_N-1:0][DW-1:0] alm_set_t;

    typedef struct packed {
        logic [DW-1:0]           ctrl;
        logic [ALM_N-1:0][FLD_N-1:0][DW-1:0] alm;
    } regs_t;

    typedef struct packed {
        logic [ALM_N-1:0] flg;
    } flag_state_t;

    // alarm 0 occupies 2..5; alarm 1 slot 0 (seconds) does not exist
    function automatic logic slot_valid(input int a, input int f);
        return (a == 0) || (f != 0);
    endfunction

    function automatic logic [AW-1:0] slot_addr(input int a, input int f);
        int r;
        r = (a == 0) ? (2 + f) : (5 + f);
        return AW'(r);
    endfunction
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_pkg::*;
(
    input  alm_set_t     al,
    input  logic [6:0]   t_sec,
    input  logic [6:0]   t_min,
    input  logic [6:0]   t_hour,
    input  logic [5:0]   t_dow,
    input  logic [5:0]   t_date,
    output logic         match
);
    logic       sec_ok, min_ok, hr_ok, dd_ok;
    logic [5:0] dd_pick;

    always_comb begin
        dd_pick = al[3][6] ? t_dow : t_date;
        sec_ok  = al[0][7] | (al[0][6:0] == t_sec);
        min_ok  = al[1][7] | (al[1][6:0] == t_min);
        hr_ok   = al[2][7] | (al[2][6:0] == t_hour);
        dd_ok   = al[3][7] | (al[3][5:0] == dd_pick);
        match   = sec_ok & min_ok & hr_ok & dd_ok;
    end
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
    import alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [ALM_N-1:0] hit,
    input  logic             clr_we,
    input  logic [ALM_N-1:0] keep_mask,
    output logic [ALM_N-1:0] flags
);
    flag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_we) s_d.flg = s_q.flg & keep_mask;
        if (tick)   s_d.flg = s_d.flg | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.flg;

    // R6
    flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flg & ~$past(s_q.flg)) != '0 |-> $past(tick));

    // R8
    flag_fall_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.flg) & ~s_q.flg) != '0 |-> $past(clr_we));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_we && hit[0]) |=> flags[0]);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [6:0]   now_sec,
    input  logic [6:0]   now_min,
    input  logic [6:0]   now_hour,
    input  logic [5:0]   now_dow,
    input  logic [5:0]   now_date,
    input  logic         reg_we,
    input  logic [3:0]   reg_addr,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    output logic         irq_n,
    output logic         wave_req
);
    regs_t            r_d, r_q;
    logic [ALM_N-1:0] hit;
    logic [ALM_N-1:0] flags;
    logic             stat_we;

    // register file: next-state
    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            if (reg_addr == ADDR_CTRL) r_d.ctrl = reg_wdata;
            for (int a = 0; a < ALM_N; a++) begin
                for (int f = 0; f < FLD_N; f++) begin
                    if (slot_valid(a, f) && reg_addr == slot_addr(a, f))
                        r_d.alm[a][f] = reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // comparators, one per alarm
    for (genvar g = 0; g < ALM_N; g++) begin : g_cmp
        alarm_cmp u_cmp (
            .al     (r_q.alm[g]),
            .t_sec  (now_sec),
            .t_min  (now_min),
            .t_hour (now_hour),
            .t_dow  (now_dow),
            .t_date (now_date),
            .match  (hit[g])
        );
    end

    assign stat_we = reg_we && (reg_addr == ADDR_STAT);

    flag_ctrl u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hit       (hit),
        .clr_we    (stat_we),
        .keep_mask (reg_wdata[ALM_N-1:0]),
        .flags     (flags)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) reg_rdata = r_q.ctrl;
        if (reg_addr == ADDR_STAT) reg_rdata = {{(DW-ALM_N){1'b0}}, flags};
        for (int a = 0; a < ALM_N; a++) begin
            for (int f = 0; f < FLD_N; f++) begin
                if (slot_valid(a, f) && reg_addr == slot_addr(a, f))
                    reg_rdata = r_q.alm[a][f];
            end
        end
    end

    always_comb begin
        irq_n    = !(r_q.ctrl[CTL_MODE] &&
                     ((flags[0] && r_q.ctrl[CTL_EN0]) || (flags[1] && r_q.ctrl[CTL_EN1])));
        wave_req = !r_q.ctrl[CTL_MODE];
    end

    // R5
    a2_at_zero_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(now_sec) == 7'h00);

    // R9
    irq_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_n) |-> $past(reg_we || tick));

    // R1
    wave_idle_low_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wave_req |-> irq_n);
endmodule

// File: tb/alarm_unit_tb.sv
module alarm_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
    logic [5:0] now_dow = '0, now_date = '0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n, wave_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alarm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_dow(now_dow), .now_date(now_date),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n), .wave_req(wave_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                            input logic [5:0] w, input logic [5:0] dt);
        now_sec = s; now_min = m; now_hour = h; now_dow = w; now_date = dt;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v); check("R1 ctrl", v, 8'h00);
        rd(4'd1, v); check("R1 status", v, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 wave_req", {7'd0, wave_req}, 8'h01);

        // R11 register map readback
        for (int a = 2; a <= 8; a++) wr(4'(a), 8'(8'h10 + a));
        for (int a = 2; a <= 8; a++) begin
            rd(4'(a), v); check("R11 readback", v, 8'(8'h10 + a));
        end
        for (int a = 9; a <= 15; a++) begin
            wr(4'(a), 8'hA5);
            rd(4'(a), v); check("R11 unmapped", v, 8'h00);
        end
        rd(4'd0, v); check("R11 ctrl untouched", v, 8'h00);

        // R2 / R3 alarm 1 sweep: mask bits m, differing fields d
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 16; d++) begin
                bit expv;
                wr(4'd1, 8'h00);
                wr(4'd2, {m[0], 7'h30});
                wr(4'd3, {m[1], 7'h45});
                wr(4'd4, {m[2], 7'h12});
                wr(4'd5, {m[3], 1'b0, 6'h15});
                set_time(d[0] ? 7'h31 : 7'h30, d[1] ? 7'h46 : 7'h45,
                         d[2] ? 7'h13 : 7'h12, 6'h3, d[3] ? 6'h16 : 6'h15);
                pulse_tick();
                expv = &(4'(m) | ~4'(d));
                rd(4'd1, v);
                if (m == 15) check("R3 all masked", {7'd0, v[0]}, 8'h01);
                else         check("R2 alarm1 field match", {7'd0, v[0]}, {7'd0, expv});
            end
        end

        // R5 alarm 2 sweep: masks m, differing d, seconds zero or not
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 8; d++) begin
                for (int z = 0; z < 2; z++) begin
                    bit expv;
                    wr(4'd1, 8'h00);
                    wr(4'd6, {m[0], 7'h45});
                    wr(4'd7, {m[1], 7'h12});
                    wr(4'd8, {m[2], 1'b0, 6'h15});
                    set_time(z == 0 ? 7'h00 : 7'h17, d[0] ? 7'h46 : 7'h45,
                             d[1] ? 7'h13 : 7'h12, 6'h3, d[2] ? 6'h16 : 6'h15);
                    pulse_tick();
                    expv = (z == 0) && (&(3'(m) | ~3'(d)));
                    rd(4'd1, v);
                    check("R5 alarm2 match", {7'd0, v[1]}, {7'd0, expv});
                end
            end
        end

        // R4 day versus date selection on alarm 1 (other fields masked)
        wr(4'd2, 8'h80); wr(4'd3, 8'h80); wr(4'd4, 8'h80);
        wr(4'd5, {2'b01, 6'h03});
        wr(4'd1, 8'h00); set_time(7'h05, 7'h05, 7'h05, 6'h3, 6'h16); pulse_tick();
        rd(4'd1, v); check("R4 day hit", {7'd0, v[0]}, 8'h01);
        wr(4'd1, 8'h00); set_time(7'h05, 7'h05, 7'h05, 6'h4, 6'h03); pulse_tick();
        rd(4'd1, v); check("R4 day miss, date equal", {7'd0, v[0]}, 8'h00);
        wr(4'd5, {2'b00, 6'h15});
        wr(4'd1, 8'h00); set_time(7'h05, 7'h05, 7'h05, 6'h15, 6'h15); pulse_tick();
        rd(4'd1, v); check("R4 date hit", {7'd0, v[0]}, 8'h01);
        wr(4'd1, 8'h00); set_time(7'h05, 7'h05, 7'h05, 6'h15, 6'h14); pulse_tick();
        rd(4'd1, v); check("R4 date miss, day equal", {7'd0, v[0]}, 8'h00);

        // R6 no tick, no flag
        wr(4'd2, 8'h80); wr(4'd5, 8'h80);
        wr(4'd1, 8'h00);
        repeat (5) @(negedge clk);
        rd(4'd1, v); check("R6 no tick", v, 8'h00);

        // R7 flags set with enables off and mode off
        wr(4'd0, 8'h00);
        wr(4'd6, 8'h80); wr(4'd7, 8'h80); wr(4'd8, 8'h80);
        set_time(7'h00, 7'h00, 7'h00, 6'h1, 6'h1); pulse_tick();
        rd(4'd1, v); check("R7 both flags", v, 8'h03);
        check("R7 irq idle", {7'd0, irq_n}, 8'h01);

        // R9 output under all control combos, both flags set
        for (int c = 0; c < 8; c++) begin
            bit e;
            wr(4'd0, 8'(c));
            e = c[2] && (c[0] || c[1]);
            check("R9 irq both flags", {7'd0, irq_n}, {7'd0, !e});
            check("R11 wave_req", {7'd0, wave_req}, {7'd0, !c[2]});
        end

        // R8 selective clear and ignored sets
        wr(4'd1, 8'hFE);
        rd(4'd1, v); check("R8 clear bit0 keep bit1", v, 8'h02);
        wr(4'd0, 8'h05);
        check("R9 only alarm1 enabled, flag clear", {7'd0, irq_n}, 8'h01);
        wr(4'd0, 8'h06);
        check("R9 alarm2 enabled, flag held", {7'd0, irq_n}, 8'h00);
        wr(4'd1, 8'hFF);
        rd(4'd1, v); check("R8 write one no set", v, 8'h02);
        wr(4'd1, 8'h00);
        rd(4'd1, v); check("R8 clear all", v, 8'h00);
        check("R9 released after clear", {7'd0, irq_n}, 8'h01);

        // R10 tick match and clear write in the same cycle
        set_time(7'h00, 7'h00, 7'h00, 6'h1, 6'h1);
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h00;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0;
        rd(4'd1, v); check("R10 set wins", v, 8'h03);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule